// File: doc/BRIEF.md
# Paged Host Register Interface for a Time-Slot Switch

This block is the host side of a time-slot switch. A small byte-wide bus with a select, a strobe, a read/write line and six address lines reaches a control register, the data memory that holds captured serial samples, and the two halves of the connection memory that steer the switch. The top address line splits the space in two. With it low, every access lands on the control register whatever the lower bits say. With it high, the lower five bits pick one of 32 bytes in a page. The control register chooses which stream's page that is and which memory it belongs to.

A split mode in the control register sends host reads to the data memory and host writes to the connection memory. Software can then read captured samples and write switching entries without rewriting the control register between the two. The serial switching logic shares the connection memory through its own read port and fills the data memory through its own write port. When a host write and a serial read meet at the same connection-memory location in the same cycle, the serial read wins and the host write is held for one cycle.

Top module: `paged_host_port`

## Requirements
- R1: After reset the control register reads 0x00. That selects stream 0 and the data memory, with split mode off.
- R2: An access with address bit 5 low reads or writes the whole control register, and address bits 4..0 have no effect. A write takes effect at the clock edge that ends the access cycle.
- R3: An access with address bit 5 high reaches location {control[2:0], address[4:0]} of the memory named by control bits 4..3. The encoding is 00 data memory, 01 connection low, 10 connection high, 11 none, and "none" reads 0x00 and ignores writes.
- R4: With control bit 7 set, reads in the page window return data memory contents. Writes in the window go to connection high when bits 4..3 are 10, and to connection low otherwise. Control register accesses are unaffected.
- R5: A host write that targets the data memory (bits 4..3 = 00, split off) changes nothing.
- R6: bus_rdata_oe is high exactly in cycles with select, strobe and read all high. Read data is valid in the same cycle, and bus_rdata is 0x00 whenever bus_rdata_oe is low.
- R7: sw_cm_lo and sw_cm_hi show, combinationally, the stored contents of both connection-memory halves at sw_rd_addr.
- R8: A serial data-memory write is stored at the clock edge, and a host read in the next cycle returns it.
- R9: A host connection-memory write to the location the serial side reads (sw_rd_en high, same address) in that cycle is held. Serial reads of that location return the old value in that cycle and in the following one, and the new value from the cycle after.
- R10: A host read of a location whose write is being held returns the held value.
- R11: When a held write and a new direct host write land on the same location in the same cycle, the direct write's value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host chip select, active high |
| bus_stb | input | 1 | Host data strobe, active high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Host address; bit 5 chooses register or page window |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| bus_rdata_oe | output | 1 | Drive enable for bus_rdata |
| sw_rd_en | input | 1 | Serial side is reading the connection memory this cycle |
| sw_rd_addr | input | 8 | Serial connection-memory read address {stream, channel} |
| sw_cm_lo | output | 8 | Connection low contents at sw_rd_addr |
| sw_cm_hi | output | 8 | Connection high contents at sw_rd_addr |
| sw_dm_we | input | 1 | Serial data-memory write enable |
| sw_dm_addr | input | 8 | Serial data-memory write address |
| sw_dm_wdata | input | 8 | Serial data-memory write data |

## Verification
The hardest case to reach from the ports is the held connection-memory write. It needs a host write and a serial read of the same location in the same cycle. Its rarest form is a held write that commits in the same cycle as a direct host write to that location. The stimulus reaches both on purpose with directed sequences: the serial read address is pinned to the page location the host writes, then the serial read is dropped while a second write hits the same byte. A long random phase then aims the serial read address at the host's current page location half of the time, so collisions also arrive mixed with control register changes and split-mode toggles.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    MSEL_DATA    = 2'b00,
    MSEL_CONN_LO = 2'b01,
    MSEL_CONN_HI = 2'b10,
    MSEL_NONE    = 2'b11
  } msel_e;

  typedef struct packed {
    logic       split;
    logic [1:0] spare;
    msel_e      msel;
    logic [2:0] stream;
  } ctrl_t;

  typedef enum logic [2:0] {
    RSRC_NONE,
    RSRC_CTRL,
    RSRC_DATA,
    RSRC_CLO,
    RSRC_CHI,
    RSRC_ZERO
  } rsrc_e;
endpackage

// File: rtl/hpi_decode.sv
module hpi_decode
  import hpi_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int STREAM_W = 3,
  localparam int WIN_AW  = ADDR_W - 1,
  localparam int MEM_AW  = STREAM_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_stb,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output ctrl_t             cr_q,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        cm_we,
  output rsrc_e             rd_src,
  output logic              rd_active
);
  logic  acc;
  logic  in_window;
  logic  cr_we;
  ctrl_t cr_d;

  always_comb begin
    acc       = bus_sel && bus_stb;
    in_window = bus_addr[ADDR_W-1];
    mem_addr  = {cr_q.stream[STREAM_W-1:0], bus_addr[WIN_AW-1:0]};
    rd_active = acc && bus_rd;
    cr_we     = acc && !bus_rd && !in_window;
  end

  // read source selection
  always_comb begin
    rd_src = RSRC_NONE;
    if (rd_active) begin
      if (!in_window) begin
        rd_src = RSRC_CTRL;
      end else if (cr_q.split) begin
        rd_src = RSRC_DATA;
      end else begin
        unique case (cr_q.msel)
          MSEL_DATA:    rd_src = RSRC_DATA;
          MSEL_CONN_LO: rd_src = RSRC_CLO;
          MSEL_CONN_HI: rd_src = RSRC_CHI;
          default:      rd_src = RSRC_ZERO;
        endcase
      end
    end
  end

  // write target selection; data memory is never written from the host
  always_comb begin
    cm_we = 2'b00;
    if (acc && !bus_rd && in_window) begin
      if (cr_q.split) begin
        if (cr_q.msel == MSEL_CONN_HI) cm_we = 2'b10;
        else                            cm_we = 2'b01;
      end else begin
        if (cr_q.msel == MSEL_CONN_LO) cm_we = 2'b01;
        if (cr_q.msel == MSEL_CONN_HI) cm_we = 2'b10;
      end
    end
  end

  always_comb begin
    cr_d = cr_q;
    if (cr_we) cr_d = ctrl_t'(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cr_q <= '0;
    else        cr_q <= cr_d;
  end

  p_cr_load_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_stb && !bus_rd && !bus_addr[ADDR_W-1])
      |=> (cr_q == ctrl_t'($past(bus_wdata))));

  p_cr_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_stb && !bus_rd && !bus_addr[ADDR_W-1]) |=> $stable(cr_q));

  p_split_write_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (cr_q.split && bus_sel && bus_stb && !bus_rd && bus_addr[ADDR_W-1])
      |-> ($countones(cm_we) == 1));
endmodule

// File: rtl/hpi_dm.sv
module hpi_dm
  import hpi_pkg::*;
#(
  parameter int AW = 8,
  localparam int DEPTH = 2 ** AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [AW-1:0]    sw_addr,
  input  logic [BUS_W-1:0] sw_wdata,
  input  logic [AW-1:0]    rd_addr,
  output logic [BUS_W-1:0] rd_data
);
  logic [BUS_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (sw_we) mem[sw_addr] <= sw_wdata;
  end

  always_comb rd_data = mem[rd_addr];

  p_dm_store_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (mem[$past(sw_addr)] == $past(sw_wdata)));
endmodule

// File: rtl/hpi_cm_half.sv
module hpi_cm_half
  import hpi_pkg::*;
#(
  parameter int AW = 8,
  localparam int DEPTH = 2 ** AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [BUS_W-1:0] host_wdata,
  output logic [BUS_W-1:0] host_rdata,
  input  logic             sw_rd_en,
  input  logic [AW-1:0]    sw_rd_addr,
  output logic [BUS_W-1:0] sw_rdata
);
  logic [BUS_W-1:0] mem [DEPTH];

  logic             collide;
  logic             direct_we;
  logic             pend_v_q,    pend_v_d;
  logic [AW-1:0]    pend_addr_q, pend_addr_d;
  logic [BUS_W-1:0] pend_data_q, pend_data_d;

  always_comb begin
    collide   = host_we && sw_rd_en && (sw_rd_addr == host_addr);
    direct_we = host_we && !collide;
  end

  // held-write next state, loaded only on a collision
  always_comb begin
    pend_v_d    = collide;
    pend_addr_d = pend_addr_q;
    pend_data_d = pend_data_q;
    if (collide) begin
      pend_addr_d = host_addr;
      pend_data_d = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_v_q    <= pend_v_d;
      pend_addr_q <= pend_addr_d;
      pend_data_q <= pend_data_d;
    end
  end

  // storage: the held write commits first, a direct write of the same cycle overrides it
  always_ff @(posedge clk) begin
    if (pend_v_q)  mem[pend_addr_q] <= pend_data_q;
    if (direct_we) mem[host_addr]   <= host_wdata;
  end

  always_comb begin
    if (pend_v_q && (pend_addr_q == host_addr)) host_rdata = pend_data_q;
    else                                        host_rdata = mem[host_addr];
    sw_rdata = mem[sw_rd_addr];
  end

  p_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (pend_v_q && (pend_addr_q == $past(host_addr))));

  p_commit_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && !(direct_we && (host_addr == pend_addr_q)))
      |=> (mem[$past(pend_addr_q)] == $past(pend_data_q)));

  p_direct_wins_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && direct_we && (host_addr == pend_addr_q))
      |=> (mem[$past(host_addr)] == $past(host_wdata)));

  p_bypass_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && (pend_addr_q == host_addr)) |-> (host_rdata == pend_data_q));
endmodule

// File: rtl/paged_host_port.sv
module paged_host_port
  import hpi_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int NUM_STREAMS = 8,
  localparam int STREAM_W   = $clog2(NUM_STREAMS),
  localparam int MEM_AW     = STREAM_W + ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_stb,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rdata_oe,
  input  logic              sw_rd_en,
  input  logic [MEM_AW-1:0] sw_rd_addr,
  output logic [7:0]        sw_cm_lo,
  output logic [7:0]        sw_cm_hi,
  input  logic              sw_dm_we,
  input  logic [MEM_AW-1:0] sw_dm_addr,
  input  logic [7:0]        sw_dm_wdata
);
  localparam int NUM_HALVES = 2;

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ctrl_t             cr_q;
  logic [MEM_AW-1:0] mem_addr;
  logic [1:0]        cm_we;
  rsrc_e             rd_src;
  logic              rd_active;
  logic [7:0]        dm_rdata;
  logic [7:0]        cm_host_rd [NUM_HALVES];
  logic [7:0]        cm_sw_rd   [NUM_HALVES];

  hpi_decode #(.ADDR_W(ADDR_W), .STREAM_W(STREAM_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync),
    .bus_sel   (bus_sel),
    .bus_stb   (bus_stb),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cr_q      (cr_q),
    .mem_addr  (mem_addr),
    .cm_we     (cm_we),
    .rd_src    (rd_src),
    .rd_active (rd_active)
  );

  hpi_dm #(.AW(MEM_AW)) u_dm (
    .clk      (clk),
    .rst_n    (rst_sync),
    .sw_we    (sw_dm_we),
    .sw_addr  (sw_dm_addr),
    .sw_wdata (sw_dm_wdata),
    .rd_addr  (mem_addr),
    .rd_data  (dm_rdata)
  );

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_cm
    hpi_cm_half #(.AW(MEM_AW)) u_half (
      .clk        (clk),
      .rst_n      (rst_sync),
      .host_we    (cm_we[g]),
      .host_addr  (mem_addr),
      .host_wdata (bus_wdata),
      .host_rdata (cm_host_rd[g]),
      .sw_rd_en   (sw_rd_en),
      .sw_rd_addr (sw_rd_addr),
      .sw_rdata   (cm_sw_rd[g])
    );
  end

  always_comb begin
    sw_cm_lo     = cm_sw_rd[0];
    sw_cm_hi     = cm_sw_rd[1];
    bus_rdata_oe = rd_active;
    unique case (rd_src)
      RSRC_CTRL: bus_rdata = cr_q;
      RSRC_DATA: bus_rdata = dm_rdata;
      RSRC_CLO:  bus_rdata = cm_host_rd[0];
      RSRC_CHI:  bus_rdata = cm_host_rd[1];
      default:   bus_rdata = '0;
    endcase
  end

  p_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_sync)
    !bus_rdata_oe |-> (bus_rdata == 8'h00));

  p_split_read_r4 : assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_rdata_oe && cr_q.split && bus_addr[ADDR_W-1]) |-> (bus_rdata == dm_rdata));

  p_none_sel_r3 : assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_rdata_oe && !cr_q.split && bus_addr[ADDR_W-1] && (cr_q.msel == MSEL_NONE))
      |-> (bus_rdata == 8'h00));
endmodule

// File: tb/sim_paged_host_port.sv
`timescale 1ns/1ps
module sim_paged_host_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_stb, bus_rd;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       bus_rdata_oe;
  logic       sw_rd_en;
  logic [7:0] sw_rd_addr;
  logic [7:0] sw_cm_lo, sw_cm_hi;
  logic       sw_dm_we;
  logic [7:0] sw_dm_addr, sw_dm_wdata;

  paged_host_port u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_stb(bus_stb), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .sw_rd_en(sw_rd_en), .sw_rd_addr(sw_rd_addr),
    .sw_cm_lo(sw_cm_lo), .sw_cm_hi(sw_cm_hi),
    .sw_dm_we(sw_dm_we), .sw_dm_addr(sw_dm_addr), .sw_dm_wdata(sw_dm_wdata)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  logic [7:0] hv [2][256];
  logic [7:0] sv [2][256];
  logic [7:0] dm [256];
  logic [7:0] m_cr;
  bit         m_pv;
  int         m_ph, m_pa;
  logic [7:0] m_pd;
  int         col_age;
  int         h, a, ms;
  bit         col_now;
  bit         cmp_on = 0;
  bit         done = 0;
  string      tag_hint = "";
  int         checks = 0;
  int         fails = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cr = 8'h00; m_pv = 0; col_age = 9;
    end else begin
      if (m_pv) begin sv[m_ph][m_pa] = m_pd; m_pv = 0; end
      col_now = 0;
      if (sw_dm_we) dm[sw_dm_addr] = sw_dm_wdata;
      if (bus_sel && bus_stb && !bus_rd) begin
        if (!bus_addr[5]) m_cr = bus_wdata;
        else begin
          a  = int'(m_cr[2:0]) * 32 + int'(bus_addr[4:0]);
          ms = int'(m_cr[4:3]);
          if (m_cr[7]) h = (ms == 2) ? 1 : 0;
          else         h = (ms == 1) ? 0 : ((ms == 2) ? 1 : -1);
          if (h >= 0) begin
            hv[h][a] = bus_wdata;
            if (sw_rd_en && int'(sw_rd_addr) == a) begin
              m_pv = 1; m_ph = h; m_pa = a; m_pd = bus_wdata; col_now = 1;
            end else sv[h][a] = bus_wdata;
          end
        end
      end
      col_age = col_now ? 0 : ((col_age < 9) ? col_age + 1 : 9);
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [7:0] exp_rd;
      logic       exp_oe;
      string      rtag;
      int         ra, rs;
      exp_oe = bus_sel && bus_stb && bus_rd;
      exp_rd = 8'h00;
      rtag   = "R3";
      ra = int'(m_cr[2:0]) * 32 + int'(bus_addr[4:0]);
      rs = int'(m_cr[4:3]);
      if (exp_oe) begin
        if (!bus_addr[5]) begin exp_rd = m_cr; rtag = "R2"; end
        else if (m_cr[7]) begin exp_rd = dm[ra]; rtag = "R4"; end
        else begin
          if (rs == 0) exp_rd = dm[ra];
          else if (rs == 1) exp_rd = hv[0][ra];
          else if (rs == 2) exp_rd = hv[1][ra];
          if (m_pv && m_pa == ra && (rs - 1) == m_ph) rtag = "R10";
        end
      end
      if (tag_hint != "") rtag = tag_hint;
      chk("R6", bus_rdata_oe, exp_oe);
      chk(rtag, bus_rdata, exp_rd);
      chk((col_age <= 1) ? "R9" : "R7", sw_cm_lo, sv[0][sw_rd_addr]);
      chk((col_age <= 1) ? "R9" : "R7", sw_cm_hi, sv[1][sw_rd_addr]);
    end
  end

  task automatic host(bit rd, logic [5:0] ad, logic [7:0] d);
    bus_sel = 1; bus_stb = 1; bus_rd = rd; bus_addr = ad; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_stb = 0; bus_rd = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_stb = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    sw_rd_en = 0; sw_rd_addr = '0; sw_dm_we = 0; sw_dm_addr = '0; sw_dm_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) tick();

    // R1: control register after reset, with stray low address bits
    bus_sel = 1; bus_stb = 1; bus_rd = 1; bus_addr = 6'h1F;
    @(negedge clk);
    chk("R1", bus_rdata, 8'h00);
    chk("R1", {7'd0, bus_rdata_oe}, 8'h01);
    tick();
    bus_sel = 0; bus_stb = 0; bus_rd = 0;
    @(negedge clk);
    chk("R6", {7'd0, bus_rdata_oe}, 8'h00);
    chk("R6", bus_rdata, 8'h00);
    tick();

    // preload data memory over the serial port
    for (int i = 0; i < 256; i++) begin
      sw_dm_we = 1; sw_dm_addr = 8'(i); sw_dm_wdata = 8'((i * 7 + 3) & 255);
      tick();
    end
    sw_dm_we = 0;
    // preload both connection-memory halves over the host bus
    for (int hf = 0; hf < 2; hf++) begin
      for (int s = 0; s < 8; s++) begin
        host(0, 6'h00, {3'b000, (hf == 0) ? 2'b01 : 2'b10, 3'(s)});
        for (int c = 0; c < 32; c++)
          host(0, 6'(32 + c), 8'(((s * 32 + c) * (hf ? 29 : 13) + (hf ? 64 : 1)) & 255));
      end
    end
    cmp_on = 1;

    // R2: register write with nonzero low bits, read with others
    host(0, 6'h15, 8'h2B);
    host(1, 6'h00, 8'h00);
    host(1, 6'h0A, 8'h00);

    // R3: every select code across several pages
    for (int s = 0; s < 8; s += 3)
      for (int m = 0; m < 4; m++) begin
        host(0, 6'h00, {3'b000, 2'(m), 3'(s)});
        for (int c = 0; c < 32; c += 9) host(1, 6'(32 + c), 8'h00);
      end
    // R3: select "none" ignores a write, checked through connection low
    host(0, 6'h00, 8'h1D);
    host(0, 6'h27, 8'h5A);
    host(1, 6'h27, 8'h00);
    host(0, 6'h00, 8'h0D);
    host(1, 6'h27, 8'h00);

    // R5: write aimed at the data memory is dropped
    host(0, 6'h02, 8'h02);
    host(0, 6'h25, 8'hEE);
    tag_hint = "R5";
    host(1, 6'h25, 8'h00);
    tag_hint = "";

    // R4: split mode, select high then select data
    host(0, 6'h00, 8'h94);
    host(0, 6'h23, 8'h77);
    host(1, 6'h23, 8'h00);
    host(1, 6'h00, 8'h00);
    host(0, 6'h00, 8'h14);
    host(1, 6'h23, 8'h00);
    host(0, 6'h00, 8'h84);
    host(0, 6'h24, 8'h66);
    host(0, 6'h00, 8'h0C);
    host(1, 6'h24, 8'h00);

    // R8: serial data-memory write then host read next cycle
    host(0, 6'h00, 8'h05);
    sw_dm_we = 1; sw_dm_addr = 8'hA9; sw_dm_wdata = 8'hC3;
    tick();
    sw_dm_we = 0;
    tag_hint = "R8";
    host(1, 6'h29, 8'h00);
    tag_hint = "";

    // R9 and R10: collision on connection low, stream 1 channel 5
    host(0, 6'h00, 8'h09);
    sw_rd_en = 1; sw_rd_addr = 8'h25;
    host(0, 6'h25, 8'hA5);
    tag_hint = "R10";
    host(1, 6'h25, 8'h00);
    tag_hint = "";
    tick(); tick();
    // R11: held write then direct write to the same byte
    host(0, 6'h25, 8'h11);
    sw_rd_en = 0;
    host(0, 6'h25, 8'h22);
    sw_rd_en = 1;
    tag_hint = "R11";
    host(1, 6'h25, 8'h00);
    @(negedge clk);
    chk("R11", sw_cm_lo, 8'h22);
    tag_hint = "";
    tick();
    sw_rd_en = 0;

    // random phase, serial reads aimed at the host page half the time
    for (int k = 0; k < 4000; k++) begin
      bus_sel  = ($urandom % 5) != 0;
      bus_stb  = ($urandom % 5) != 0;
      bus_rd   = $urandom % 2;
      bus_addr = {($urandom % 5) != 0, 5'($urandom)};
      bus_wdata = 8'($urandom);
      sw_rd_en = $urandom % 2;
      sw_rd_addr = ($urandom % 2) ? {m_cr[2:0], bus_addr[4:0]} : 8'($urandom);
      sw_dm_we = ($urandom % 3) == 0;
      sw_dm_addr = ($urandom % 2) ? {m_cr[2:0], 5'($urandom)} : 8'($urandom);
      sw_dm_wdata = 8'($urandom);
      tick();
    end
    bus_sel = 0; bus_stb = 0; sw_rd_en = 0; sw_dm_we = 0;
    tick(); tick();
    summary();
  end
endmodule